// File: doc/BRIEF.md
# Transaction Mode and Checkpoint Controller

This per-core controller tracks whether the core is inside a hardware transaction. It takes begin, end and explicit-abort commands from the pipeline, and abort requests from the cache for data conflicts and for buffer overflow. It also holds a small architectural register file that the core writes through a simple write port.

When the outermost transaction begins, the controller copies the whole register file into a shadow copy in one cycle. It also latches the fallback address that comes with that begin. Nested begins and ends only move a flattened depth counter. When the counter returns to zero, the controller raises a commit request toward the cache and holds it until the cache acknowledges.

Any abort returns the core to non-transactional mode, restores the registers from the shadow copy in a single step and records a cause word. The controller then presents the latched fallback address as the place where execution resumes.

Top module: `txn_ckpt_ctrl`

## Requirements
- R1: After reset, txActive, nestDepth, commitReq and abortPulse are 0, abortStatus and resumeAddr are 0, and every architectural register reads 0.
- R2: When regWrEn is high and no abort occurs in that cycle, register regWrIdx holds regWrData from the next cycle on. Register i appears at regsOut[i*REG_W +: REG_W].
- R3: A begin while not transactional sets txActive and a depth of 1 in the next cycle. It snapshots the register values held before any write made in that same cycle, and it latches fallbackAddr.
- R4: A begin while transactional and below the maximum depth adds one to nestDepth. It does not retake the snapshot or change the latched fallback address. An end at a depth above 1 subtracts one.
- R5: An end at depth 1 gives a depth of 0 with commitReq high and txActive still high. Both stay high until commitAck, after which both are low and the registers keep their transactional values.
- R6: An abort (conflictReq or overflowReq while transactional, an explicit abort or a nest overflow while active) has the following effects in the next cycle. txActive, nestDepth and commitReq are 0. abortPulse is high for that one cycle. The registers equal the snapshot, overriding any write in the abort cycle. resumeAddr equals the fallback latched at the outermost begin.
- R7: abortStatus holds bit 0 for an explicit abort, bit 1 for a conflict, bit 2 for an overflow and bit 3 for a fault. Bits [31:24] hold abortImm for an explicit abort and are 0 otherwise, and all other bits are 0. The word holds its value until the next abort.
- R8: An end while not transactional is a fault. abortPulse rises and abortStatus becomes 8. The registers are not restored, resumeAddr is unchanged and txActive stays 0.
- R9: A begin at depth 2**DEPTH_W-1, or overflowReq while transactional, aborts with the overflow cause.
- R10: A conflict or overflow request in the same cycle as commitAck wins: the transaction aborts and does not commit.
- R11: When several abort causes arrive together, only one cause bit is set. Conflict ranks above overflow, and overflow ranks above explicit.
- R12: Begin, end and explicit abort have no effect while a commit is pending. conflictReq, overflowReq and cmdAbort have no effect while not transactional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdBegin | input | 1 | Begin-transaction command |
| cmdEnd | input | 1 | End-transaction command |
| cmdAbort | input | 1 | Explicit abort command |
| abortImm | input | 8 | Immediate reported with an explicit abort |
| fallbackAddr | input | ADDR_W | Resume address given with a begin |
| conflictReq | input | 1 | Data conflict abort request from the cache |
| overflowReq | input | 1 | Buffer overflow abort request from the cache |
| commitAck | input | 1 | Cache accepts the pending commit |
| regWrEn | input | 1 | Architectural register write enable |
| regWrIdx | input | IDX_W | Register index to write |
| regWrData | input | REG_W | Register write data |
| regsOut | output | NUM_REGS*REG_W | Flattened architectural registers |
| txActive | output | 1 | Core is in transactional mode |
| nestDepth | output | DEPTH_W | Flattened nesting depth |
| commitReq | output | 1 | Commit request toward the cache |
| abortPulse | output | 1 | One-cycle abort notice |
| abortStatus | output | 32 | Cause word of the last abort |
| resumeAddr | output | ADDR_W | Non-transactional resume address |

## Verification
Commit acceptance and a conflict abort can land in the same cycle. The bench drives commitAck and conflictReq together while a commit is pending, after writing a register inside the transaction. It expects an abort with the conflict cause, the register rolled back and commitReq dropped, not a commit. A restore and a register write are also driven into one abort cycle, and the snapshot is expected to win over the written value.

// File: rtl/txc_pkg.sv
package txc_pkg;
  localparam int CAUSE_EXPLICIT = 0;
  localparam int CAUSE_CONFLICT = 1;
  localparam int CAUSE_OVERFLOW = 2;
  localparam int CAUSE_FAULT    = 3;
  localparam int IMM_LSB        = 24;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_COMMIT = 2'd2
  } txState_e;

  typedef struct packed {
    logic snapTake;
    logic restore;
  } dpStrobe_t;
endpackage

// File: rtl/txc_dpath.sv
module txc_dpath
  import txc_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic                      regWrEn,
  input  logic [IDX_W-1:0]          regWrIdx,
  input  logic [REG_W-1:0]          regWrData,
  output logic [NUM_REGS*REG_W-1:0] regsOut
);
  logic [REG_W-1:0] archReg [NUM_REGS];
  logic [REG_W-1:0] shadowReg [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        archReg[i]   <= '0;
        shadowReg[i] <= '0;
      end else begin
        if (strobe.restore)
          archReg[i] <= shadowReg[i];
        else if (regWrEn && regWrIdx == IDX_W'(i))
          archReg[i] <= regWrData;
        if (strobe.snapTake)
          shadowReg[i] <= archReg[i];
      end
    end
    assign regsOut[i*REG_W +: REG_W] = archReg[i];
  end
endmodule

// File: rtl/txc_ctrl.sv
module txc_ctrl
  import txc_pkg::*;
#(
  parameter int DEPTH_W = 3,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdBegin,
  input  logic               cmdEnd,
  input  logic               cmdAbort,
  input  logic [7:0]         abortImm,
  input  logic [ADDR_W-1:0]  fallbackAddr,
  input  logic               conflictReq,
  input  logic               overflowReq,
  input  logic               commitAck,
  output dpStrobe_t          strobe,
  output logic               txActive,
  output logic [DEPTH_W-1:0] nestDepth,
  output logic               commitReq,
  output logic               abortPulse,
  output logic [31:0]        abortStatus,
  output logic [ADDR_W-1:0]  resumeAddr
);
  localparam int MAX_DEPTH = (1 << DEPTH_W) - 1;

  txState_e          state;
  logic [ADDR_W-1:0] fallbackReg;
  logic              inTx, atMax, abConflict, abOverflow, abExplicit, isFault, doAbort;
  logic [31:0]       statusNext;

  always_comb begin
    inTx       = (state != ST_IDLE);
    atMax      = (nestDepth == DEPTH_W'(MAX_DEPTH));
    abConflict = inTx && conflictReq;
    abOverflow = inTx && (overflowReq || (state == ST_ACTIVE && cmdBegin && atMax));
    abExplicit = (state == ST_ACTIVE) && cmdAbort;
    isFault    = (state == ST_IDLE) && cmdEnd;
    doAbort    = abConflict || abOverflow || abExplicit;

    statusNext = '0;
    if (abConflict)
      statusNext[CAUSE_CONFLICT] = 1'b1;
    else if (abOverflow)
      statusNext[CAUSE_OVERFLOW] = 1'b1;
    else if (abExplicit) begin
      statusNext[CAUSE_EXPLICIT]    = 1'b1;
      statusNext[IMM_LSB +: 8]      = abortImm;
    end else if (isFault)
      statusNext[CAUSE_FAULT] = 1'b1;

    strobe.restore  = doAbort;
    strobe.snapTake = (state == ST_IDLE) && cmdBegin && !cmdEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      nestDepth   <= '0;
      abortPulse  <= 1'b0;
      abortStatus <= '0;
      resumeAddr  <= '0;
      fallbackReg <= '0;
    end else begin
      abortPulse <= doAbort || isFault;
      if (doAbort) begin
        state       <= ST_IDLE;
        nestDepth   <= '0;
        abortStatus <= statusNext;
        resumeAddr  <= fallbackReg;
      end else if (isFault) begin
        abortStatus <= statusNext;
      end else begin
        unique case (state)
          ST_IDLE: if (cmdBegin) begin
            state       <= ST_ACTIVE;
            nestDepth   <= DEPTH_W'(1);
            fallbackReg <= fallbackAddr;
          end
          ST_ACTIVE: if (cmdEnd) begin
            nestDepth <= nestDepth - DEPTH_W'(1);
            if (nestDepth == DEPTH_W'(1)) state <= ST_COMMIT;
          end else if (cmdBegin) begin
            nestDepth <= nestDepth + DEPTH_W'(1);
          end
          ST_COMMIT: if (commitAck) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign txActive  = inTx;
  assign commitReq = (state == ST_COMMIT);
endmodule

// File: rtl/txn_ckpt_ctrl.sv
module txn_ckpt_ctrl
  import txc_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 16,
  parameter int DEPTH_W  = 3,
  parameter int ADDR_W   = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdBegin,
  input  logic                      cmdEnd,
  input  logic                      cmdAbort,
  input  logic [7:0]                abortImm,
  input  logic [ADDR_W-1:0]         fallbackAddr,
  input  logic                      conflictReq,
  input  logic                      overflowReq,
  input  logic                      commitAck,
  input  logic                      regWrEn,
  input  logic [IDX_W-1:0]          regWrIdx,
  input  logic [REG_W-1:0]          regWrData,
  output logic [NUM_REGS*REG_W-1:0] regsOut,
  output logic                      txActive,
  output logic [DEPTH_W-1:0]        nestDepth,
  output logic                      commitReq,
  output logic                      abortPulse,
  output logic [31:0]               abortStatus,
  output logic [ADDR_W-1:0]         resumeAddr
);
  dpStrobe_t strobe;

  txc_ctrl #(.DEPTH_W(DEPTH_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdBegin(cmdBegin), .cmdEnd(cmdEnd),
    .cmdAbort(cmdAbort), .abortImm(abortImm), .fallbackAddr(fallbackAddr),
    .conflictReq(conflictReq), .overflowReq(overflowReq), .commitAck(commitAck),
    .strobe(strobe), .txActive(txActive), .nestDepth(nestDepth),
    .commitReq(commitReq), .abortPulse(abortPulse), .abortStatus(abortStatus),
    .resumeAddr(resumeAddr)
  );

  txc_dpath #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrEn(regWrEn),
    .regWrIdx(regWrIdx), .regWrData(regWrData), .regsOut(regsOut)
  );
endmodule

// File: rtl/txn_ckpt_ctrl_chk.sv
module txn_ckpt_ctrl_chk #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 16,
  parameter int DEPTH_W  = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      cmdBegin,
  input logic                      cmdEnd,
  input logic                      conflictReq,
  input logic                      overflowReq,
  input logic                      commitAck,
  input logic                      regWrEn,
  input logic [NUM_REGS*REG_W-1:0] regsOut,
  input logic                      txActive,
  input logic [DEPTH_W-1:0]        nestDepth,
  input logic                      commitReq,
  input logic                      abortPulse,
  input logic [31:0]               abortStatus
);
  p_begin_enters_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!txActive && cmdBegin && !cmdEnd) |=> (txActive && nestDepth == DEPTH_W'(1)));

  p_pending_shape_r5: assert property (@(posedge clk) disable iff (!rstN)
    commitReq |-> (txActive && nestDepth == '0));

  p_pending_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (commitReq && !commitAck && !conflictReq && !overflowReq) |=> commitReq);

  p_ack_drops_r5: assert property (@(posedge clk) disable iff (!rstN)
    (commitReq && commitAck) |=> !commitReq);

  p_abort_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (!txActive && nestDepth == '0 && !commitReq));

  p_one_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> ($countones(abortStatus[3:0]) == 1));

  p_imm_only_explicit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (abortPulse && !abortStatus[0]) |-> (abortStatus[31:24] == 8'h00));

  p_fault_keeps_regs_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!txActive && cmdEnd && !regWrEn) |=> (regsOut == $past(regsOut)));

  p_conflict_beats_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    (commitReq && commitAck && conflictReq) |=> (abortPulse && abortStatus[1]));
endmodule

bind txn_ckpt_ctrl txn_ckpt_ctrl_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .DEPTH_W(DEPTH_W)
) uChk (
  .clk(clk), .rstN(rstN), .cmdBegin(cmdBegin), .cmdEnd(cmdEnd),
  .conflictReq(conflictReq), .overflowReq(overflowReq), .commitAck(commitAck),
  .regWrEn(regWrEn), .regsOut(regsOut), .txActive(txActive),
  .nestDepth(nestDepth), .commitReq(commitReq), .abortPulse(abortPulse),
  .abortStatus(abortStatus)
);

// File: tb/tb_txn_ckpt_ctrl.sv
module tb_txn_ckpt_ctrl;
  localparam int NUM_REGS = 4;
  localparam int REG_W    = 16;
  localparam int DEPTH_W  = 3;
  localparam int ADDR_W   = 16;
  localparam int IDX_W    = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdBegin = 0, cmdEnd = 0, cmdAbort = 0;
  logic [7:0] abortImm = '0;
  logic [ADDR_W-1:0] fallbackAddr = '0;
  logic conflictReq = 0, overflowReq = 0, commitAck = 0;
  logic regWrEn = 0;
  logic [IDX_W-1:0] regWrIdx = '0;
  logic [REG_W-1:0] regWrData = '0;
  logic [NUM_REGS*REG_W-1:0] regsOut;
  logic txActive, commitReq, abortPulse;
  logic [DEPTH_W-1:0] nestDepth;
  logic [31:0] abortStatus;
  logic [ADDR_W-1:0] resumeAddr;

  always #5 clk = ~clk;

  txn_ckpt_ctrl #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .DEPTH_W(DEPTH_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .cmdBegin(cmdBegin), .cmdEnd(cmdEnd), .cmdAbort(cmdAbort),
    .abortImm(abortImm), .fallbackAddr(fallbackAddr), .conflictReq(conflictReq),
    .overflowReq(overflowReq), .commitAck(commitAck), .regWrEn(regWrEn),
    .regWrIdx(regWrIdx), .regWrData(regWrData), .regsOut(regsOut), .txActive(txActive),
    .nestDepth(nestDepth), .commitReq(commitReq), .abortPulse(abortPulse),
    .abortStatus(abortStatus), .resumeAddr(resumeAddr)
  );

  typedef struct {
    string                     req;
    logic                      act;
    logic [DEPTH_W-1:0]        dep;
    logic                      creq;
    logic                      ap;
    logic [31:0]               st;
    logic [ADDR_W-1:0]         ra;
    logic [NUM_REGS*REG_W-1:0] regs;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [REG_W-1:0] mr [NUM_REGS];
  logic [REG_W-1:0] msh [NUM_REGS];
  logic eAct = 0, eCreq = 0;
  logic [DEPTH_W-1:0] eDep = '0;
  logic [31:0] eSt = '0;
  logic [ADDR_W-1:0] eRa = '0, eFb = '0;

  function automatic logic [NUM_REGS*REG_W-1:0] packRegs();
    logic [NUM_REGS*REG_W-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i*REG_W +: REG_W] = mr[i];
    return v;
  endfunction

  // monitor: pops one expected item per cycle and compares
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (txActive !== e.act || nestDepth !== e.dep || commitReq !== e.creq ||
          abortPulse !== e.ap || abortStatus !== e.st || resumeAddr !== e.ra ||
          regsOut !== e.regs) begin
        errors++;
        $display("FAIL %s: act=%b dep=%0d creq=%b ap=%b st=%h ra=%h regs=%h expected act=%b dep=%0d creq=%b ap=%b st=%h ra=%h regs=%h",
          e.req, txActive, nestDepth, commitReq, abortPulse, abortStatus, resumeAddr, regsOut,
          e.act, e.dep, e.creq, e.ap, e.st, e.ra, e.regs);
      end
    end
  end

  // driver: inputs already set at a negedge; push expectation after the edge
  task automatic cycle(string req, logic ap);
    exp_t e;
    @(posedge clk);
    e.req = req; e.act = eAct; e.dep = eDep; e.creq = eCreq; e.ap = ap;
    e.st = eSt; e.ra = eRa; e.regs = packRegs();
    expQ.push_back(e);
    @(negedge clk);
    cmdBegin = 0; cmdEnd = 0; cmdAbort = 0; abortImm = '0;
    conflictReq = 0; overflowReq = 0; commitAck = 0; regWrEn = 0;
  endtask

  task automatic wr(int idx, logic [REG_W-1:0] d);
    regWrEn = 1; regWrIdx = IDX_W'(idx); regWrData = d;
    mr[idx] = d;
  endtask

  task automatic outerBegin(logic [ADDR_W-1:0] fb);
    cmdBegin = 1; fallbackAddr = fb;
    for (int i = 0; i < NUM_REGS; i++) msh[i] = mr[i];
    eFb = fb; eAct = 1; eDep = 1;
  endtask

  task automatic restoreModel(logic [31:0] st);
    for (int i = 0; i < NUM_REGS; i++) mr[i] = msh[i];
    eAct = 0; eDep = 0; eCreq = 0; eSt = st; eRa = eFb;
  endtask

  initial begin
    for (int i = 0; i < NUM_REGS; i++) begin mr[i] = '0; msh[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    cycle("R1 reset state", 0);

    wr(0, 16'h1111); cycle("R2 write r0", 0);
    wr(1, 16'h2222); cycle("R2 write r1", 0);
    wr(2, 16'h3333); cycle("R2 write r2", 0);
    wr(3, 16'h4444); cycle("R2 write r3", 0);

    // R3: outermost begin with a same-cycle write; snapshot takes old value
    outerBegin(16'hBEEF); wr(3, 16'h4545); cycle("R3 outer begin", 0);
    wr(0, 16'hAAAA); cycle("R2 write in tx", 0);
    cmdBegin = 1; fallbackAddr = 16'h1234; eDep = 2; cycle("R4 nested begin", 0);
    cmdEnd = 1; eDep = 1; cycle("R4 inner end", 0);

    // R6: conflict abort with a write in the same cycle; restore wins
    conflictReq = 1; wr(1, 16'h9999); restoreModel(32'h0000_0002);
    cycle("R6 R7 conflict abort restore", 1);
    cycle("R7 status held", 0);

    conflictReq = 1; overflowReq = 1; cmdAbort = 1; abortImm = 8'h77;
    cycle("R12 abort requests ignored when idle", 0);

    outerBegin(16'h0100); wr(1, 16'h5555); cycle("R3 begin with write", 0);
    cmdAbort = 1; abortImm = 8'hA5; restoreModel(32'hA500_0001);
    cycle("R6 R7 explicit abort", 1);

    cmdEnd = 1; eSt = 32'h0000_0008; cycle("R8 end outside tx", 1);

    // R9: nest to the maximum, then one more begin
    outerBegin(16'h0200); cycle("R9 depth 1", 0);
    for (int d = 2; d <= (1 << DEPTH_W) - 1; d++) begin
      cmdBegin = 1; fallbackAddr = 16'hFFFF; eDep = DEPTH_W'(d);
      cycle("R4 R9 nest up", 0);
    end
    wr(2, 16'h7A7A); cycle("R2 write at max depth", 0);
    cmdBegin = 1; restoreModel(32'h0000_0004); cycle("R9 nest overflow abort", 1);

    // R5: commit handshake
    outerBegin(16'h0300); cycle("R3 begin for commit", 0);
    wr(2, 16'h7777); cycle("R2 write before commit", 0);
    cmdEnd = 1; eDep = 0; eCreq = 1; cycle("R5 outer end raises commit", 0);
    cycle("R5 commit held", 0);
    cmdBegin = 1; cycle("R12 begin ignored while pending", 0);
    cmdEnd = 1; cmdAbort = 1; cycle("R12 end and abort ignored while pending", 0);
    commitAck = 1; eAct = 0; eCreq = 0; cycle("R5 commit accepted", 0);

    outerBegin(16'h0400); cycle("R3 begin", 0);
    overflowReq = 1; restoreModel(32'h0000_0004); cycle("R9 buffer overflow abort", 1);

    // R10: conflict in the same cycle as the commit acknowledge
    outerBegin(16'h0500); cycle("R3 begin", 0);
    wr(0, 16'h0BAD); cycle("R2 write in tx", 0);
    cmdEnd = 1; eDep = 0; eCreq = 1; cycle("R5 pending", 0);
    commitAck = 1; conflictReq = 1; restoreModel(32'h0000_0002);
    cycle("R10 conflict beats ack", 1);

    // R11: priority among simultaneous causes
    outerBegin(16'h0600); cycle("R3 begin", 0);
    cmdAbort = 1; abortImm = 8'h3C; conflictReq = 1; overflowReq = 1;
    restoreModel(32'h0000_0002); cycle("R11 conflict wins", 1);
    outerBegin(16'h0700); cycle("R3 begin", 0);
    cmdAbort = 1; abortImm = 8'h3C; overflowReq = 1;
    restoreModel(32'h0000_0004); cycle("R11 overflow beats explicit", 1);

    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule